// File: doc/BRIEF.md
# Three-Wire Serial Control Register Receiver

This block is a write-only slave on a three-wire control bus made of a bus clock, a data line and a mode line. A controller first sends an address byte with the mode line low. That byte names the device and picks a register group. It then sends any number of data bytes with the mode line high, and the leading bits of each data byte pick the register inside that group. Nothing is ever sent back to the controller.

All three bus lines are asynchronous to the system clock. They pass through a synchronizer, and bus clock rising edges are detected in the system clock domain, so the system clock has to run several times faster than the bus clock. The register contents appear as parallel fields: right and left volume, bass, treble, the decoded bits of control register 0, and control register 1 together with its lock-speed field.

Top module: `ctl3w_rx`

## Requirements
- R1: A byte is eight data bits sampled on bus clock rising edges, least significant bit first. A byte received with the mode line low is an address byte. Its bits 7..2 are the device address and its bits 1..0 are the transfer type. An address byte never changes a register.
- R2: Only device address 000101 selects the receiver. After any other address, data bytes are ignored until a matching address byte arrives.
- R3: Transfer type 00 selects the audio group and type 10 selects the control group. Types 01 and 11 deselect the receiver, so the data bytes that follow have no effect.
- R4: A register changes only once the eighth bit of a data byte has been received. A byte with seven bits so far leaves every output unchanged.
- R5: A selection stays in force for any number of following data bytes, until the next address byte.
- R6: In the audio group, data bits 7..6 = 00 write bits 5..0 to the right volume and 01 write bits 5..0 to the left volume.
- R7: In the audio group, data bits 7..6 = 10 write bits 4..0 to bass and 11 write bits 4..0 to treble. Bit 5 is ignored.
- R8: In the control group, data bit 7 = 0 writes bits 6..0 to control register 0. Its outputs are: reset from bit 0, soft mute from bit 1, sync mode from bit 2, channel swap from bit 3, de-emphasis from bit 4, and audio mode from bits 6..5.
- R9: In the control group, data bit 7 = 1 writes bits 6..0 to control register 1. The lock-speed output carries bits 6..5 of that register: 0 = 512, 1 = 2048, 2 = 4096, 3 = 16384 samples.
- R10: A change of level on the mode line throws away a partly received byte. The next bit then starts a new byte.
- R11: After reset both volumes equal the VOL_INIT parameter (default 8), and every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Bus clock |
| ser_data_i | input | 1 | Bus data |
| ser_mode_i | input | 1 | Bus mode line: low for address, high for data |
| vol_right_o | output | 6 | Right volume |
| vol_left_o | output | 6 | Left volume |
| bass_o | output | 5 | Bass setting |
| treble_o | output | 5 | Treble setting |
| dac_reset_o | output | 1 | Control register 0 bit 0 |
| soft_mute_o | output | 1 | Control register 0 bit 1 |
| sync_mode_o | output | 1 | Control register 0 bit 2 |
| chan_swap_o | output | 1 | Control register 0 bit 3 |
| deemph_o | output | 1 | Control register 0 bit 4 |
| audio_mode_o | output | 2 | Control register 0 bits 6..5 |
| ctrl1_o | output | 7 | Control register 1 |
| lock_speed_o | output | 2 | Control register 1 bits 6..5 |

## Verification
The bench targets the following corner cases:
- A foreign device address. A receiver that kept its old selection would write volume.
- Transfer types 01 and 11. A decoder that looked only at bit 1 would treat type 11 as control.
- A byte stopped after seven bits. A receiver that wrote early, or that counted wrongly, would change volume before the eighth bit.
- A mode toggle in the middle of a byte. Without the clear, the old bits would merge with the new byte and corrupt the written value.
- Bit 5 set in a bass write, which a five-bit field must drop.
- Several data bytes after one address, which a receiver that deselects after each byte would drop.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    XFER_AUDIO = 2'b00,
    XFER_RSV0  = 2'b01,
    XFER_CTRL  = 2'b10,
    XFER_RSV1  = 2'b11
  } xfer_t;

  typedef enum logic [1:0] {
    AUD_VOL_R  = 2'b00,
    AUD_VOL_L  = 2'b01,
    AUD_BASS   = 2'b10,
    AUD_TREBLE = 2'b11
  } aud_sel_t;

  typedef struct packed {
    logic [1:0] mode;
    logic       deemph;
    logic       swap;
    logic       sync_sel;
    logic       mute;
    logic       rst;
  } ctrl0_t;

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  logic [STAGES-1:0][N-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) begin
        stage_q[s] <= stage_q[s-1];
      end
      stage_q[0] <= async_i;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              smode_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_is_addr_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_d_q, smode_d_q;
  logic              rise, mode_chg;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              valid_q, valid_d;
  logic              addr_q, addr_d;
  logic              shift_en, out_en;

  assign rise     = sclk_i & ~sclk_d_q;
  assign mode_chg = smode_i ^ smode_d_q;

  always_comb begin
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    out_d    = out_q;
    addr_d   = addr_q;
    valid_d  = 1'b0;
    shift_en = 1'b0;
    out_en   = 1'b0;
    if (mode_chg) begin
      cnt_d = '0;
    end else if (rise) begin
      shift_en = 1'b1;
      shreg_d  = {sdat_i, shreg_q[BYTE_W-1:1]};
      if (cnt_q == LAST_BIT) begin
        cnt_d   = '0;
        valid_d = 1'b1;
        out_en  = 1'b1;
        out_d   = shreg_d;
        addr_d  = ~smode_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q  <= 1'b0;
      smode_d_q <= 1'b0;
      cnt_q     <= '0;
      shreg_q   <= '0;
      out_q     <= '0;
      valid_q   <= 1'b0;
      addr_q    <= 1'b0;
    end else begin
      sclk_d_q  <= sclk_i;
      smode_d_q <= smode_i;
      valid_q   <= valid_d;
      cnt_q     <= cnt_d;
      if (shift_en) shreg_q <= shreg_d;
      if (out_en) begin
        out_q  <= out_d;
        addr_q <= addr_d;
      end
    end
  end

  assign byte_valid_o   = valid_q;
  assign byte_o         = out_q;
  assign byte_is_addr_o = addr_q;

  // R4: a completed byte is reported only in the cycle after a bus clock edge
  assert_byte_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> $past(rise));

  // R10: a mode change restarts the bit count and reports no byte
  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt_q == '0) && !byte_valid_o);

endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101,
  parameter int VOL_W  = 6,
  parameter int TONE_W = 5,
  parameter int CTRL_W = 7,
  parameter logic [VOL_W-1:0] VOL_INIT = 6'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_is_addr_i,
  output logic [VOL_W-1:0]  vol_r_o,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o,
  output logic [CTRL_W-1:0] ctrl0_o,
  output logic [CTRL_W-1:0] ctrl1_o
);

  logic              sel_q, sel_d;
  xfer_t             grp_q, grp_d;
  logic              addr_we, data_ok;
  logic              we_vr, we_vl, we_bass, we_treble, we_c0, we_c1;
  logic [VOL_W-1:0]  vol_r_q, vol_l_q;
  logic [TONE_W-1:0] bass_q, treble_q;
  logic [CTRL_W-1:0] ctrl0_q, ctrl1_q;
  xfer_t             rx_type;
  aud_sel_t          aud_sel;

  assign rx_type = xfer_t'(byte_i[1:0]);
  assign aud_sel = aud_sel_t'(byte_i[7:6]);
  assign addr_we = byte_valid_i & byte_is_addr_i;
  assign data_ok = byte_valid_i & ~byte_is_addr_i & sel_q;

  always_comb begin
    sel_d     = sel_q;
    grp_d     = grp_q;
    we_vr     = 1'b0;
    we_vl     = 1'b0;
    we_bass   = 1'b0;
    we_treble = 1'b0;
    we_c0     = 1'b0;
    we_c1     = 1'b0;
    if (addr_we) begin
      sel_d = (byte_i[7:2] == DEV_ADDR) &&
              (rx_type == XFER_AUDIO || rx_type == XFER_CTRL);
      grp_d = rx_type;
    end else if (data_ok) begin
      if (grp_q == XFER_AUDIO) begin
        unique case (aud_sel)
          AUD_VOL_R:  we_vr     = 1'b1;
          AUD_VOL_L:  we_vl     = 1'b1;
          AUD_BASS:   we_bass   = 1'b1;
          AUD_TREBLE: we_treble = 1'b1;
        endcase
      end else if (grp_q == XFER_CTRL) begin
        we_c0 = ~byte_i[7];
        we_c1 = byte_i[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      grp_q    <= XFER_AUDIO;
      vol_r_q  <= VOL_INIT;
      vol_l_q  <= VOL_INIT;
      bass_q   <= '0;
      treble_q <= '0;
      ctrl0_q  <= '0;
      ctrl1_q  <= '0;
    end else begin
      if (addr_we) begin
        sel_q <= sel_d;
        grp_q <= grp_d;
      end
      if (we_vr)     vol_r_q  <= byte_i[VOL_W-1:0];
      if (we_vl)     vol_l_q  <= byte_i[VOL_W-1:0];
      if (we_bass)   bass_q   <= byte_i[TONE_W-1:0];
      if (we_treble) treble_q <= byte_i[TONE_W-1:0];
      if (we_c0)     ctrl0_q  <= byte_i[CTRL_W-1:0];
      if (we_c1)     ctrl1_q  <= byte_i[CTRL_W-1:0];
    end
  end

  assign vol_r_o  = vol_r_q;
  assign vol_l_o  = vol_l_q;
  assign bass_o   = bass_q;
  assign treble_o = treble_q;
  assign ctrl0_o  = ctrl0_q;
  assign ctrl1_o  = ctrl1_q;

  logic [2*VOL_W+2*TONE_W+2*CTRL_W-1:0] all_regs;
  assign all_regs = {vol_r_q, vol_l_q, bass_q, treble_q, ctrl0_q, ctrl1_q};

  // R1: an address byte leaves every register untouched
  assert_addr_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && byte_is_addr_i) |=> $stable(all_regs));

  // R2: data received while deselected writes nothing
  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !byte_is_addr_i && !sel_q) |=> $stable(all_regs));

  // R3: an unused transfer type leaves the receiver deselected
  assert_unused_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && byte_is_addr_i && byte_i[0]) |=> !sel_q);

  // R6: a right-volume byte lands in the right-volume register
  assert_vol_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !byte_is_addr_i && sel_q && grp_q == XFER_AUDIO &&
     byte_i[7:6] == 2'b00) |=> vol_r_q == $past(byte_i[VOL_W-1:0]));

  // R8: a control byte with bit 7 low lands in control register 0
  assert_ctrl0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !byte_is_addr_i && sel_q && grp_q == XFER_CTRL &&
     !byte_i[7]) |=> ctrl0_q == $past(byte_i[CTRL_W-1:0]));

endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101,
  parameter int SYNC_STAGES = 2,
  parameter int VOL_W  = 6,
  parameter int TONE_W = 5,
  parameter int CTRL_W = 7,
  parameter logic [VOL_W-1:0] VOL_INIT = 6'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_mode_i,
  output logic [VOL_W-1:0]  vol_right_o,
  output logic [VOL_W-1:0]  vol_left_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o,
  output logic              dac_reset_o,
  output logic              soft_mute_o,
  output logic              sync_mode_o,
  output logic              chan_swap_o,
  output logic              deemph_o,
  output logic [1:0]        audio_mode_o,
  output logic [CTRL_W-1:0] ctrl1_o,
  output logic [1:0]        lock_speed_o
);

  logic              rst_meta_q, rst_sync_q;
  logic [2:0]        bus_s;
  logic              byte_valid, byte_is_addr;
  logic [BYTE_W-1:0] rx_byte;
  logic [CTRL_W-1:0] ctrl0_raw;
  ctrl0_t            ctrl0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctl3w_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i ({ser_mode_i, ser_data_i, ser_clk_i}),
    .sync_o  (bus_s)
  );

  ctl3w_shift shift_i (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .sclk_i         (bus_s[0]),
    .sdat_i         (bus_s[1]),
    .smode_i        (bus_s[2]),
    .byte_valid_o   (byte_valid),
    .byte_o         (rx_byte),
    .byte_is_addr_o (byte_is_addr)
  );

  ctl3w_regs #(
    .DEV_ADDR (DEV_ADDR),
    .VOL_W    (VOL_W),
    .TONE_W   (TONE_W),
    .CTRL_W   (CTRL_W),
    .VOL_INIT (VOL_INIT)
  ) regs_i (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .byte_valid_i   (byte_valid),
    .byte_i         (rx_byte),
    .byte_is_addr_i (byte_is_addr),
    .vol_r_o        (vol_right_o),
    .vol_l_o        (vol_left_o),
    .bass_o         (bass_o),
    .treble_o       (treble_o),
    .ctrl0_o        (ctrl0_raw),
    .ctrl1_o        (ctrl1_o)
  );

  assign ctrl0        = ctrl0_t'(ctrl0_raw);
  assign dac_reset_o  = ctrl0.rst;
  assign soft_mute_o  = ctrl0.mute;
  assign sync_mode_o  = ctrl0.sync_sel;
  assign chan_swap_o  = ctrl0.swap;
  assign deemph_o     = ctrl0.deemph;
  assign audio_mode_o = ctrl0.mode;
  assign lock_speed_o = ctrl1_o[6:5];

endmodule

// File: tb/ctl3w_rx_tb.sv
module ctl3w_rx_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_mode = 1'b0;
  logic [5:0] vol_r, vol_l;
  logic [4:0] bass, treble;
  logic dac_rst, mute, syncm, swap, deemph;
  logic [1:0] amode, lspeed;
  logic [6:0] ctrl1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  ctl3w_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_mode_i(ser_mode), .vol_right_o(vol_r), .vol_left_o(vol_l),
    .bass_o(bass), .treble_o(treble), .dac_reset_o(dac_rst),
    .soft_mute_o(mute), .sync_mode_o(syncm), .chan_swap_o(swap),
    .deemph_o(deemph), .audio_mode_o(amode), .ctrl1_o(ctrl1),
    .lock_speed_o(lspeed)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = b[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(12);
  endtask

  task automatic send_byte(input logic mode, input logic [7:0] b);
    ser_mode = mode;
    wait_clk(8);
    send_bits(b, 8);
  endtask

  task automatic t_reset;
    chk("R11 vol right", vol_r, 8);
    chk("R11 vol left", vol_l, 8);
    chk("R11 bass/treble", {bass, treble}, 0);
    chk("R11 ctrl0 fields", {dac_rst, mute, syncm, swap, deemph, amode}, 0);
    chk("R11 ctrl1", ctrl1, 0);
  endtask

  task automatic t_volume;
    send_byte(1'b0, 8'h14);
    chk("R1 address byte writes nothing", vol_r, 8);
    send_byte(1'b1, 8'h2A);
    chk("R6 vol right", vol_r, 42);
    send_byte(1'b1, 8'h55);
    chk("R6 vol left", vol_l, 21);
    chk("R6 vol right kept", vol_r, 42);
  endtask

  task automatic t_tone;
    send_byte(1'b1, 8'hBF);
    chk("R7 bass bit5 ignored", bass, 31);
    send_byte(1'b1, 8'hE3);
    chk("R7 treble", treble, 3);
    send_byte(1'b1, 8'h11);
    chk("R5 selection persists", vol_r, 17);
  endtask

  task automatic t_control;
    send_byte(1'b0, 8'h16);
    send_byte(1'b1, 8'h55);
    chk("R8 reset bit", dac_rst, 1);
    chk("R8 mute/sync/swap/deemph", {mute, syncm, swap, deemph}, 4'b0101);
    chk("R8 audio mode", amode, 2);
    chk("R8 volume untouched", vol_r, 17);
    send_byte(1'b1, 8'hE3);
    chk("R9 ctrl1", ctrl1, 7'h63);
    chk("R9 lock speed", lspeed, 3);
  endtask

  task automatic t_wrong_addr;
    send_byte(1'b0, 8'h18);
    send_byte(1'b1, 8'h05);
    chk("R2 foreign address ignored", vol_r, 17);
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h05);
    chk("R2 match reselects", vol_r, 5);
  endtask

  task automatic t_unused_type;
    send_byte(1'b0, 8'h15);
    send_byte(1'b1, 8'h51);
    chk("R3 type 01 ignored", vol_l, 21);
    send_byte(1'b0, 8'h17);
    send_byte(1'b1, 8'h80);
    chk("R3 type 11 ignored", ctrl1, 7'h63);
  endtask

  task automatic t_partial;
    send_byte(1'b0, 8'h14);
    ser_mode = 1'b1;
    wait_clk(8);
    send_bits(8'h1C, 7);
    chk("R4 seven bits no write", vol_r, 5);
    send_bits(8'h00, 1);
    chk("R4 eighth bit writes", vol_r, 28);
  endtask

  task automatic t_mode_clear;
    send_bits(8'hFF, 5);
    ser_mode = 1'b0;
    wait_clk(10);
    ser_mode = 1'b1;
    wait_clk(10);
    send_bits(8'h09, 8);
    chk("R10 partial byte discarded", vol_r, 9);
    chk("R10 left untouched", vol_l, 21);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_volume();
    t_tone();
    t_control();
    t_wrong_addr();
    t_unused_type();
    t_partial();
    t_mode_clear();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule